// File: doc/BRIEF.md
# MSI Event Queue Writer

This block sits between the inbound message-signalled-interrupt path and host memory. Every inbound MSI carries a vector number and a 16-bit data value. A software-written mapping table sends the vector to one of several circular event queues that live in host memory. The block forms a 32-bit entry from the message and writes it to the queue slot named by that queue's tail pointer, using a single-beat request/acknowledge write port. Only after the acknowledge returns does it advance the tail. The per-queue interrupt line, which is registered, can rise only after that.

Software drains a queue by reading entries from memory and then writing the queue's head pointer register. A queue whose next slot would collide with the head is full. A message aimed at a full queue is consumed without any memory write, and a sticky overflow flag for that queue records the loss. Steering a vector to a different CPU means rewriting its mapping entry so that it lands in a different queue. Queue memory is expected to be zeroed by software before use, so a set marker bit tells a fresh entry apart from an empty slot.

Top module: `msi_evq_writer`

## Requirements
- R1: After reset msi_ready is 1, mem_req is 0, irq_out is 0, every head, tail, enable and overflow bit is 0, and mapping entry v holds queue v mod NUM_Q.
- R2: The entry written for an MSI has bit 31 set to 1, bits 30:16 holding the vector number zero-extended, and bits 15:0 holding the MSI data.
- R3: The entry address is base + queue*256 + tail*4, where base is register word 0. The 6-bit tail wraps from 63 to 0.
- R4: A queue's tail advances by one on the clock edge where mem_ack is seen for its write, and at no other time. Tail q is read at register word 8+q.
- R5: Only one write is outstanding at a time. msi_ready is 0 from the cycle after an accept until the cycle after mem_ack, and mem_req stays high with a stable address and data until mem_ack.
- R6: When (tail+1) mod 64 equals head, an MSI for that queue is consumed with no memory write and the tail is left unchanged. Bit q of register word 2 is then set. That bit is sticky and is cleared only by writing 1 to it.
- R7: irq_out[q] is a registered level equal to (enable bit q of register word 1) AND (head q differs from tail q). It therefore rises one cycle after the tail edge, never with it.
- R8: Register word 16+v holds the destination queue of vector v. It is readable and writable, and a rewrite redirects later messages of that vector.
- R9: Head q is written and read at register word 4+q. A head write frees queue slots for the full test of R6 and clears irq_out[q] (R7) when head meets tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| msi_valid | input | 1 | Inbound MSI present |
| msi_ready | output | 1 | Block can accept an MSI this cycle |
| msi_vector | input | VEC_W | Inbound vector number |
| msi_data | input | 16 | Inbound MSI data value |
| mem_req | output | 1 | Memory write request, held until acknowledged |
| mem_addr | output | ADDR_W | Byte address of the entry being written |
| mem_wdata | output | 32 | Entry word being written |
| mem_ack | input | 1 | Memory write completed |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| irq_out | output | NUM_Q | Per-queue level interrupt |

## Verification
The bench fills one queue until its tail wraps from 63 to 0. A design with a wrong pointer width or modulus would then write outside the 256-byte region, or would never report full. It makes the head sit one slot past the tail and checks that the next message produces no memory request and sets only that queue's overflow bit. A design that checked full with the wrong comparison would overwrite unread entries. It samples irq_out in the cycle the tail moves and again in the cycle after, which exposes an interrupt raised ahead of the tail. It stalls the acknowledge for several cycles to catch a second accept or a moving address while a write is pending.

// File: rtl/msi_evq_pkg.sv
package msi_evq_pkg;

  localparam int REG_AW = 6;

  localparam logic [REG_AW-1:0] RA_BASE = 6'd0;
  localparam logic [REG_AW-1:0] RA_IEN  = 6'd1;
  localparam logic [REG_AW-1:0] RA_OVF  = 6'd2;
  localparam int HEAD_W0 = 4;
  localparam int TAIL_W0 = 8;
  localparam int MAP_W0  = 16;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_WRITE = 1'b1
  } wr_state_e;

  function automatic logic [31:0] make_entry(input logic [14:0] vec,
                                             input logic [15:0] data);
    return {1'b1, vec, data};
  endfunction

endpackage

// File: rtl/msi_evq_rst_sync.sv
module msi_evq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/msi_evq_regs.sv
module msi_evq_regs
  import msi_evq_pkg::*;
#(
  parameter int NUM_Q   = 4,
  parameter int NUM_VEC = 16,
  parameter int PTR_W   = 6,
  parameter int Q_W     = 2,
  parameter int ADDR_W  = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_we,
  input  logic [REG_AW-1:0]             reg_addr,
  input  logic [31:0]                   reg_wdata,
  output logic [31:0]                   reg_rdata,
  input  logic [NUM_Q-1:0][PTR_W-1:0]   tail,
  input  logic [NUM_Q-1:0]              ovf,
  output logic [ADDR_W-1:0]             base,
  output logic [NUM_Q-1:0]              ien,
  output logic [NUM_Q-1:0]              ovf_clr,
  output logic [NUM_Q-1:0][PTR_W-1:0]   head,
  output logic [NUM_VEC-1:0][Q_W-1:0]   qmap
);

  logic [ADDR_W-1:0]            base_q, base_d;
  logic [NUM_Q-1:0]             ien_q, ien_d;
  logic [NUM_Q-1:0][PTR_W-1:0]  head_q, head_d;
  logic [NUM_VEC-1:0][Q_W-1:0]  map_q, map_d;

  // next-state
  always_comb begin
    base_d = base_q;
    ien_d  = ien_q;
    head_d = head_q;
    map_d  = map_q;
    if (reg_addr == RA_BASE) base_d = reg_wdata[ADDR_W-1:0];
    if (reg_addr == RA_IEN)  ien_d  = reg_wdata[NUM_Q-1:0];
    for (int q = 0; q < NUM_Q; q++) begin
      if (reg_addr == REG_AW'(HEAD_W0 + q)) head_d[q] = reg_wdata[PTR_W-1:0];
    end
    for (int v = 0; v < NUM_VEC; v++) begin
      if (reg_addr == REG_AW'(MAP_W0 + v)) map_d[v] = reg_wdata[Q_W-1:0];
    end
  end

  // registers, enabled by the write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ien_q  <= '0;
      head_q <= '0;
      for (int v = 0; v < NUM_VEC; v++) map_q[v] <= Q_W'(v % NUM_Q);
    end else if (reg_we) begin
      base_q <= base_d;
      ien_q  <= ien_d;
      head_q <= head_d;
      map_q  <= map_d;
    end
  end

  // write-one-to-clear pulse for the overflow flags
  assign ovf_clr = (reg_we && reg_addr == RA_OVF) ? reg_wdata[NUM_Q-1:0] : '0;

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == RA_BASE) reg_rdata = 32'(base_q);
    if (reg_addr == RA_IEN)  reg_rdata = 32'(ien_q);
    if (reg_addr == RA_OVF)  reg_rdata = 32'(ovf);
    for (int q = 0; q < NUM_Q; q++) begin
      if (reg_addr == REG_AW'(HEAD_W0 + q)) reg_rdata = 32'(head_q[q]);
      if (reg_addr == REG_AW'(TAIL_W0 + q)) reg_rdata = 32'(tail[q]);
    end
    for (int v = 0; v < NUM_VEC; v++) begin
      if (reg_addr == REG_AW'(MAP_W0 + v)) reg_rdata = 32'(map_q[v]);
    end
  end

  assign base = base_q;
  assign ien  = ien_q;
  assign head = head_q;
  assign qmap = map_q;

endmodule

// File: rtl/msi_evq_engine.sv
module msi_evq_engine
  import msi_evq_pkg::*;
#(
  parameter int NUM_Q   = 4,
  parameter int NUM_VEC = 16,
  parameter int VEC_W   = 4,
  parameter int PTR_W   = 6,
  parameter int Q_W     = 2,
  parameter int ADDR_W  = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          msi_valid,
  output logic                          msi_ready,
  input  logic [VEC_W-1:0]              msi_vector,
  input  logic [15:0]                   msi_data,
  output logic                          mem_req,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [31:0]                   mem_wdata,
  input  logic                          mem_ack,
  input  logic [ADDR_W-1:0]             base,
  input  logic [NUM_Q-1:0][PTR_W-1:0]   head,
  input  logic [NUM_VEC-1:0][Q_W-1:0]   qmap,
  input  logic [NUM_Q-1:0]              ovf_clr,
  output logic [NUM_Q-1:0][PTR_W-1:0]   tail,
  output logic [NUM_Q-1:0]              ovf
);

  localparam int Q_SH = PTR_W + 2;   // bytes per queue = entries * 4
  localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

  wr_state_e                    state_q, state_d;
  logic [ADDR_W-1:0]            addr_q, addr_d;
  logic [31:0]                  wdata_q, wdata_d;
  logic [Q_W-1:0]               cq_q, cq_d;
  logic [NUM_Q-1:0][PTR_W-1:0]  tail_q, tail_d;
  logic [NUM_Q-1:0]             ovf_q, ovf_d;

  logic [Q_W-1:0]   sel_q;
  logic [PTR_W-1:0] sel_tail;
  logic             sel_full;
  logic             accept;
  logic             cap_en;
  logic             tail_en;

  assign sel_q    = qmap[msi_vector];
  assign sel_tail = tail_q[sel_q];
  assign sel_full = (sel_tail + PTR_ONE) == head[sel_q];
  assign accept   = (state_q == ST_IDLE) && msi_valid;
  assign cap_en   = accept && !sel_full;
  assign tail_en  = (state_q == ST_WRITE) && mem_ack;

  // next-state
  always_comb begin
    state_d = state_q;
    addr_d  = base + (ADDR_W'(sel_q) << Q_SH) + (ADDR_W'(sel_tail) << 2);
    wdata_d = make_entry(15'(msi_vector), msi_data);
    cq_d    = sel_q;
    tail_d  = tail_q;
    ovf_d   = ovf_q & ~ovf_clr;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (sel_full) ovf_d[sel_q] = 1'b1;
          else          state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (mem_ack) begin
          tail_d[cq_q] = tail_q[cq_q] + PTR_ONE;
          state_d      = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ovf_q   <= '0;
    end else begin
      state_q <= state_d;
      ovf_q   <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      cq_q    <= '0;
    end else if (cap_en) begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      cq_q    <= cq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tail_q <= '0;
    else if (tail_en) tail_q <= tail_d;
  end

  assign msi_ready = (state_q == ST_IDLE);
  assign mem_req   = (state_q == ST_WRITE);
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign tail      = tail_q;
  assign ovf       = ovf_q;

endmodule

// File: rtl/msi_evq_irq.sv
module msi_evq_irq #(
  parameter int NUM_Q = 4,
  parameter int PTR_W = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_Q-1:0]              ien,
  input  logic [NUM_Q-1:0][PTR_W-1:0]   head,
  input  logic [NUM_Q-1:0][PTR_W-1:0]   tail,
  output logic [NUM_Q-1:0]              irq
);
  for (genvar g = 0; g < NUM_Q; g++) begin : g_line
    logic pend_d, irq_q;
    assign pend_d = ien[g] && (head[g] != tail[g]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= pend_d;
    end
    assign irq[g] = irq_q;
  end
endmodule

// File: rtl/msi_evq_writer.sv
module msi_evq_writer
  import msi_evq_pkg::*;
#(
  parameter int NUM_Q    = 4,
  parameter int NUM_VEC  = 16,
  parameter int EQ_DEPTH = 64,
  parameter int ADDR_W   = 32,
  localparam int VEC_W   = $clog2(NUM_VEC),
  localparam int PTR_W   = $clog2(EQ_DEPTH),
  localparam int Q_W     = $clog2(NUM_Q)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msi_valid,
  output logic              msi_ready,
  input  logic [VEC_W-1:0]  msi_vector,
  input  logic [15:0]       msi_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NUM_Q-1:0]  irq_out
);

  logic                          rst_n_s;
  logic [ADDR_W-1:0]             base_w;
  logic [NUM_Q-1:0]              ien_w;
  logic [NUM_Q-1:0]              ovf_clr_w;
  logic [NUM_Q-1:0]              ovf_w;
  logic [NUM_Q-1:0][PTR_W-1:0]   head_w;
  logic [NUM_Q-1:0][PTR_W-1:0]   tail_w;
  logic [NUM_VEC-1:0][Q_W-1:0]   map_w;

  msi_evq_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  msi_evq_regs #(
    .NUM_Q(NUM_Q), .NUM_VEC(NUM_VEC), .PTR_W(PTR_W), .Q_W(Q_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .tail      (tail_w),
    .ovf       (ovf_w),
    .base      (base_w),
    .ien       (ien_w),
    .ovf_clr   (ovf_clr_w),
    .head      (head_w),
    .qmap      (map_w)
  );

  msi_evq_engine #(
    .NUM_Q(NUM_Q), .NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .PTR_W(PTR_W),
    .Q_W(Q_W), .ADDR_W(ADDR_W)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .msi_valid  (msi_valid),
    .msi_ready  (msi_ready),
    .msi_vector (msi_vector),
    .msi_data   (msi_data),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .base       (base_w),
    .head       (head_w),
    .qmap       (map_w),
    .ovf_clr    (ovf_clr_w),
    .tail       (tail_w),
    .ovf        (ovf_w)
  );

  msi_evq_irq #(.NUM_Q(NUM_Q), .PTR_W(PTR_W)) u_irq (
    .clk   (clk),
    .rst_n (rst_n_s),
    .ien   (ien_w),
    .head  (head_w),
    .tail  (tail_w),
    .irq   (irq_out)
  );

endmodule

// File: rtl/msi_evq_checker.sv
module msi_evq_checker #(
  parameter int NUM_Q  = 4,
  parameter int PTR_W  = 6,
  parameter int ADDR_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    msi_ready,
  input logic                    mem_req,
  input logic                    mem_ack,
  input logic [ADDR_W-1:0]       mem_addr,
  input logic [31:0]             mem_wdata,
  input logic [NUM_Q-1:0]        irq_out,
  input logic [NUM_Q-1:0]        ien,
  input logic [NUM_Q*PTR_W-1:0]  tail
);

  // R5: no new accept while a write is pending
  a_r5_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !msi_ready);

  // R5: request held with stable payload until acknowledged
  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

  // R5: ready returns in the cycle after the acknowledge
  a_r5_ready_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> msi_ready);

  // R4: tails move only after a completed write
  a_r4_tail_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tail) |-> $past(mem_req && mem_ack));

  // R7: no interrupt on a line whose enable was off
  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & ~$past(ien)) == '0);

endmodule

bind msi_evq_writer msi_evq_checker #(
  .NUM_Q(NUM_Q), .PTR_W(PTR_W), .ADDR_W(ADDR_W)
) u_msi_evq_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .msi_ready (msi_ready),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .irq_out   (irq_out),
  .ien       (ien_w),
  .tail      (tail_w)
);

// File: tb/msi_evq_writer_bench.sv
module msi_evq_writer_bench;

  localparam logic [31:0] BASE = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msi_valid = 1'b0;
  logic        msi_ready;
  logic [3:0]  msi_vector = '0;
  logic [15:0] msi_data = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  irq_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  msi_evq_writer u_msi_evq_writer (
    .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_ready(msi_ready),
    .msi_vector(msi_vector), .msi_data(msi_data), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  // row: [31:28] vector, [27:24] ack delay, [23:22] queue, [21:16] slot, [15:0] data
  localparam logic [31:0] TBL [8] = '{
    {4'd1,  4'd0, 2'd1, 6'd0, 16'h1111},
    {4'd5,  4'd2, 2'd1, 6'd1, 16'h2222},
    {4'd2,  4'd1, 2'd2, 6'd0, 16'h3333},
    {4'd0,  4'd3, 2'd0, 6'd0, 16'h4444},
    {4'd7,  4'd0, 2'd3, 6'd0, 16'h5555},
    {4'd9,  4'd1, 2'd1, 6'd2, 16'h6666},
    {4'd15, 4'd2, 2'd3, 6'd1, 16'h7777},
    {4'd12, 4'd0, 2'd0, 6'd1, 16'h8888}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] exp_entry(input logic [3:0] v, input logic [15:0] d);
    return {1'b1, 11'd0, v, d};
  endfunction

  // Sends one MSI; expect_write says whether a memory request must follow.
  task automatic send(input string req, input logic [3:0] v, input logic [15:0] d,
                      input int dly, input bit expect_write, input logic [31:0] exp_addr);
    @(negedge clk);
    msi_valid = 1'b1; msi_vector = v; msi_data = d;
    @(negedge clk);
    msi_valid = 1'b0;
    check({req, " req"}, 32'(mem_req), 32'(expect_write));
    if (expect_write && mem_req) begin
      check({req, " R3 addr"}, mem_addr, exp_addr);
      check({req, " R2 data"}, mem_wdata, exp_entry(v, d));
      for (int k = 0; k < dly; k++) begin
        @(negedge clk);
        check({req, " R5 busy"}, {30'd0, msi_ready, mem_req}, 32'd1);
      end
      mem_ack = 1'b1;
      @(negedge clk);
      mem_ack = 1'b0;
      check({req, " R5 ready back"}, {30'd0, msi_ready, mem_req}, 32'd2);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 ready/req", {30'd0, msi_ready, mem_req}, 32'd2);
    check("R1 irq", 32'(irq_out), 32'd0);
    rd(6'd8, r);  check("R1 tail0", r, 32'd0);
    rd(6'd5, r);  check("R1 head1", r, 32'd0);
    rd(6'd2, r);  check("R1 ovf", r, 32'd0);
    rd(6'd21, r); check("R1 map5", r, 32'd1);
    rd(6'd30, r); check("R1 map14", r, 32'd2);

    wr(6'd0, BASE);

    // table walk: R2 R3 R5 R8 default map
    for (int i = 0; i < 8; i++) begin
      send("R3 tbl", TBL[i][31:28], TBL[i][15:0], int'(TBL[i][27:24]), 1'b1,
           BASE + 32'(TBL[i][23:22]) * 256 + 32'(TBL[i][21:16]) * 4);
    end

    // R4 tails after table
    rd(6'd8, r);  check("R4 tail0", r, 32'd2);
    rd(6'd9, r);  check("R4 tail1", r, 32'd3);
    rd(6'd10, r); check("R4 tail2", r, 32'd1);
    rd(6'd11, r); check("R4 tail3", r, 32'd2);

    // R7 enable gates the line
    @(negedge clk);
    check("R7 irq disabled", 32'(irq_out), 32'd0);
    wr(6'd1, 32'hF);
    @(negedge clk);
    check("R7 irq enabled", 32'(irq_out), 32'hF);

    // R9 head write drains queue 1
    wr(6'd5, 32'd3);
    rd(6'd5, r); check("R9 head1 readback", r, 32'd3);
    check("R9 R7 irq1 cleared", 32'(irq_out), 32'hD);

    // R7 ordering: tail moves first, line rises one cycle later
    send("R7 order", 4'd1, 16'hABCD, 0, 1'b1, BASE + 256 + 12);
    #1 check("R7 irq1 not with tail", 32'(irq_out[1]), 32'd0);
    rd(6'd9, r); check("R4 tail1 advanced", r, 32'd4);
    check("R7 irq1 after tail", 32'(irq_out[1]), 32'd1);

    // R6 full queue 0: tail 2, head 3
    wr(6'd4, 32'd3);
    send("R6 full q0", 4'd0, 16'h0BAD, 0, 1'b0, 32'd0);
    rd(6'd8, r); check("R6 tail0 kept", r, 32'd2);
    rd(6'd2, r); check("R6 ovf set", r, 32'd1);
    wr(6'd2, 32'd0);
    rd(6'd2, r); check("R6 ovf sticky", r, 32'd1);
    wr(6'd2, 32'd1);
    rd(6'd2, r); check("R6 ovf cleared", r, 32'd0);

    // R3 wrap on queue 2: head 1, fill slots 1..63
    wr(6'd6, 32'd1);
    for (int i = 1; i < 64; i++) begin
      send("R3 wrap", 4'd2, 16'(i), i % 3, 1'b1, BASE + 512 + 32'(i) * 4);
    end
    rd(6'd10, r); check("R3 tail2 wrapped", r, 32'd0);
    send("R6 full after wrap", 4'd2, 16'h1234, 0, 1'b0, 32'd0);
    rd(6'd2, r); check("R6 ovf q2", r, 32'd4);
    rd(6'd10, r); check("R6 tail2 kept", r, 32'd0);

    // R8 remap vector 2 to queue 3
    wr(6'd18, 32'd3);
    rd(6'd18, r); check("R8 map2 readback", r, 32'd3);
    send("R8 remap", 4'd2, 16'h5A5A, 1, 1'b1, BASE + 768 + 8);
    rd(6'd11, r); check("R8 tail3", r, 32'd3);
    rd(6'd10, r); check("R8 tail2 untouched", r, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule